// File: doc/BRIEF.md
# Ten-bit Character Disparity and Control Checker

This block is the front end of a ten-to-eight-bit line decoder. It runs on the byte-rate clock and takes one 10-bit received character per cycle, marked by a valid strobe. Each character is cut into an upper 6-bit sub-block and a lower 4-bit sub-block. The ones in each part are counted, and the full-word count drives a running-disparity tracker.

The block raises an error flag in two cases: a sub-block has an illegal imbalance, or a character pushes the line further in the direction it already leans. It raises a control flag when the character exactly matches one entry of a parameter list of control patterns. The control flag and the sub-block check depend only on the received word and never on the running disparity. The disparity state can be preset from outside at any slot, which lets a link restart from a known polarity. Every result leaves the block four clock cycles after its character enters. Since a single corrupted bit can look legal locally, its disparity error may only show up on a later character.

Top module: `tenb_disp_front`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first character has passed through, `out_valid`, `out_err` and `out_ctrl` are 0 and `out_rd` is 2'b01.
- R2: A character presented with `in_valid` high on clock edge k produces its results, with `out_valid` high, after edge k+3, so they are visible during the fourth cycle. `out_valid` follows `in_valid` with exactly that delay.
- R3: Bits [9:4] form the 6-bit sub-block and bits [3:0] the 4-bit sub-block. A sub-block whose ones minus zeros lies outside -4..+4 is a code violation and sets `out_err` for that character. For the defaults, this means an upper part of all ones or all zeros. Every 4-bit value is legal.
- R4: The running disparity is encoded as 2'b01 negative, 2'b10 positive and 2'b00 neutral. After a valid character with more than five ones it becomes 2'b10. With fewer than five it becomes 2'b01. With exactly five it is unchanged. `out_rd` shows the state after the character.
- R5: When `load_rd` is high in a slot, the state seen by that slot is `load_rd_val`, with 2'b11 taken as 2'b00, instead of the tracked state. The slot may be valid or a bubble.
- R6: A valid character with more than five ones while the state before it is positive, or fewer than five ones while it is negative, sets `out_err`. A neutral prior state never causes this error.
- R7: In a slot without a valid character, `out_err` and `out_ctrl` are 0, and `out_rd` keeps the previous state unless R5 applies.
- R8: `out_ctrl` is 1 for a valid character equal to one of the `COMMA_LIST` entries, and it is independent of the running disparity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A character is present on `in_word` |
| in_word | input | 10 | Received character, upper six bits first |
| load_rd | input | 1 | Preset the disparity state seen by this slot |
| load_rd_val | input | 2 | Preset value (01 neg, 10 pos, 00/11 neutral) |
| out_valid | output | 1 | Results belong to a character |
| out_rd | output | 2 | Running disparity after the character |
| out_err | output | 1 | Disparity or code violation detected |
| out_ctrl | output | 1 | Character matches a control pattern |

## Verification
On every cycle, the assertions check the four-cycle valid latency, the quiet outputs of empty slots, that the state never takes the unused code, that the state changes only for a character or a preset, that an illegal upper sub-block always gives an error, and that the control flag only comes with a valid result. The bench scenarios are what show that the polarity sequence and the same-sign error are right across long streams. They also show presets on data and on bubbles, the neutral handling of the 2'b11 preset, and that control patterns match whatever the current polarity.

// File: rtl/tenb_pkg.sv
package tenb_pkg;
    localparam int unsigned WORD_W_DEF  = 10;
    localparam int unsigned HI_W_DEF    = 6;
    localparam int unsigned MAX_SUB_DEF = 4;

    typedef logic [1:0] rd_t;
    localparam rd_t RD_NEUTRAL = 2'b00;
    localparam rd_t RD_NEG     = 2'b01;
    localparam rd_t RD_POS     = 2'b10;

    function automatic rd_t rd_clean(input rd_t v);
        return (v == 2'b11) ? RD_NEUTRAL : v;
    endfunction
endpackage

// File: rtl/tenb_ones_count.sv
module tenb_ones_count #(
    parameter int unsigned W  = 6,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < int'(W); i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/tenb_comma_match.sv
module tenb_comma_match #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned NUM    = 3,
    parameter logic [NUM-1:0][WORD_W-1:0] LIST = '0
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o
);
    logic [NUM-1:0] hit_vec;

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit_vec[g] = (word_i == LIST[g]);
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/tenb_rd_tracker.sv
module tenb_rd_tracker
    import tenb_pkg::*;
#(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned TCW    = $clog2(WORD_W + 1)
) (
    input  logic           valid_i,
    input  rd_t            base_rd_i,
    input  logic [TCW-1:0] ones_i,
    input  logic           code_bad_i,
    output rd_t            rd_next_o,
    output logic           err_o
);
    localparam int unsigned HALF = WORD_W / 2;

    logic heavy;
    logic light;

    always_comb begin
        heavy = (int'(ones_i) * 2) > int'(WORD_W);
        light = (int'(ones_i) * 2) < int'(WORD_W);
        rd_next_o = base_rd_i;
        err_o     = 1'b0;
        if (valid_i) begin
            if (heavy) begin
                rd_next_o = RD_POS;
            end else if (light) begin
                rd_next_o = RD_NEG;
            end
            err_o = code_bad_i
                  | (heavy && (base_rd_i == RD_POS))
                  | (light && (base_rd_i == RD_NEG));
        end
    end

    logic unused_half;
    assign unused_half = (HALF == 0);
endmodule

// File: rtl/tenb_disp_front.sv
module tenb_disp_front
    import tenb_pkg::*;
#(
    parameter int unsigned WORD_W    = WORD_W_DEF,
    parameter int unsigned HI_W      = HI_W_DEF,
    parameter int unsigned MAX_SUB   = MAX_SUB_DEF,
    parameter rd_t         RD_RESET  = RD_NEG,
    parameter int unsigned NUM_COMMA = 3,
    parameter logic [NUM_COMMA-1:0][WORD_W-1:0] COMMA_LIST =
        {10'b0011110100, 10'b1100000101, 10'b0011111010}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              load_rd,
    input  logic [1:0]        load_rd_val,
    output logic              out_valid,
    output logic [1:0]        out_rd,
    output logic              out_err,
    output logic              out_ctrl
);
    localparam int unsigned LO_W = WORD_W - HI_W;
    localparam int unsigned HCW  = $clog2(HI_W + 1);
    localparam int unsigned LCW  = $clog2(LO_W + 1);
    localparam int unsigned TCW  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              valid;
        logic              load;
        rd_t               load_val;
        logic [WORD_W-1:0] word;
    } s1_t;

    typedef struct packed {
        logic           valid;
        logic           load;
        rd_t            load_val;
        logic [TCW-1:0] ones;
        logic           code_bad;
        logic           ctrl;
    } s2_t;

    typedef struct packed {
        logic valid;
        rd_t  rd;
        logic err;
        logic ctrl;
    } res_t;

    typedef struct packed {
        s1_t  s1;
        s2_t  s2;
        res_t s3;
        res_t s4;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // stage 2 helpers
    logic [HCW-1:0] cnt_hi;
    logic [LCW-1:0] cnt_lo;
    logic           comma_hit;
    logic           hi_bad, lo_bad;

    tenb_ones_count #(.W(HI_W), .CW(HCW)) u_cnt_hi (
        .bits_i  (pipe_q.s1.word[WORD_W-1 -: HI_W]),
        .count_o (cnt_hi)
    );

    tenb_ones_count #(.W(LO_W), .CW(LCW)) u_cnt_lo (
        .bits_i  (pipe_q.s1.word[LO_W-1:0]),
        .count_o (cnt_lo)
    );

    tenb_comma_match #(.WORD_W(WORD_W), .NUM(NUM_COMMA), .LIST(COMMA_LIST)) u_comma (
        .word_i (pipe_q.s1.word),
        .hit_o  (comma_hit)
    );

    always_comb begin
        hi_bad = ((int'(cnt_hi) * 2) > int'(HI_W + MAX_SUB))
              || ((int'(cnt_hi) * 2 + int'(MAX_SUB)) < int'(HI_W));
        lo_bad = ((int'(cnt_lo) * 2) > int'(LO_W + MAX_SUB))
              || ((int'(cnt_lo) * 2 + int'(MAX_SUB)) < int'(LO_W));
    end

    // stage 3 helpers
    rd_t  base_rd;
    rd_t  rd_next;
    logic trk_err;

    assign base_rd = pipe_q.s2.load ? pipe_q.s2.load_val : pipe_q.s3.rd;

    tenb_rd_tracker #(.WORD_W(WORD_W), .TCW(TCW)) u_trk (
        .valid_i    (pipe_q.s2.valid),
        .base_rd_i  (base_rd),
        .ones_i     (pipe_q.s2.ones),
        .code_bad_i (pipe_q.s2.code_bad),
        .rd_next_o  (rd_next),
        .err_o      (trk_err)
    );

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.valid    = in_valid;
        pipe_d.s1.load     = load_rd;
        pipe_d.s1.load_val = rd_clean(load_rd_val);
        pipe_d.s1.word     = in_word;

        pipe_d.s2.valid    = pipe_q.s1.valid;
        pipe_d.s2.load     = pipe_q.s1.load;
        pipe_d.s2.load_val = pipe_q.s1.load_val;
        pipe_d.s2.ones     = TCW'(cnt_hi) + TCW'(cnt_lo);
        pipe_d.s2.code_bad = hi_bad | lo_bad;
        pipe_d.s2.ctrl     = pipe_q.s1.valid & comma_hit;

        pipe_d.s3.valid    = pipe_q.s2.valid;
        pipe_d.s3.rd       = rd_next;
        pipe_d.s3.err      = trk_err;
        pipe_d.s3.ctrl     = pipe_q.s2.ctrl;

        pipe_d.s4          = pipe_q.s3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q       <= '0;
            pipe_q.s3.rd <= RD_RESET;
            pipe_q.s4.rd <= RD_RESET;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s4.valid;
    assign out_rd    = pipe_q.s4.rd;
    assign out_err   = pipe_q.s4.err;
    assign out_ctrl  = pipe_q.s4.ctrl;
endmodule

// File: rtl/tenb_disp_front_chk.sv
module tenb_disp_front_chk #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned HI_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              load_rd,
    input logic              out_valid,
    input logic [1:0]        out_rd,
    input logic              out_err,
    input logic              out_ctrl
);
    logic [2:0] since_rst;
    logic [HI_W-1:0] hi_part;

    assign hi_part = in_word[WORD_W-1 -: HI_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5) |-> (out_valid == $past(in_valid, 4)));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_err && !out_ctrl));

    p_rd_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_rd != 2'b11);

    p_rd_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd5) && (out_rd != $past(out_rd)))
            |-> (out_valid || $past(load_rd, 4)));

    p_hi_violation_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd5) && $past(in_valid, 4)
            && (($past(hi_part, 4) == '1) || ($past(hi_part, 4) == '0)))
            |-> out_err);

    p_ctrl_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ctrl |-> out_valid);
endmodule

bind tenb_disp_front tenb_disp_front_chk #(.WORD_W(WORD_W), .HI_W(HI_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .load_rd   (load_rd),
    .out_valid (out_valid),
    .out_rd    (out_rd),
    .out_err   (out_err),
    .out_ctrl  (out_ctrl)
);

// File: tb/tenb_disp_front_tb.sv
module tenb_disp_front_tb_top;
    localparam int NC = 3;
    localparam logic [NC-1:0][9:0] CTRL_PATS =
        {10'b0011110100, 10'b1100000101, 10'b0011111010};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_word = '0;
    logic       load_rd = 1'b0;
    logic [1:0] load_rd_val = '0;
    logic       out_valid;
    logic [1:0] out_rd;
    logic       out_err;
    logic       out_ctrl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tenb_disp_front #(.NUM_COMMA(NC), .COMMA_LIST(CTRL_PATS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .load_rd(load_rd), .load_rd_val(load_rd_val),
        .out_valid(out_valid), .out_rd(out_rd), .out_err(out_err), .out_ctrl(out_ctrl)
    );

    // behavioural reference: running state plus a 4-deep result delay line
    logic [1:0] m_rd;
    logic       e_v[4];
    logic [1:0] e_rd[4];
    logic       e_err[4];
    logic       e_ctrl[4];

    always @(posedge clk) begin
        logic [1:0] base;
        int ones, hi_ones;
        logic err, ctl;
        if (!rst_n) begin
            m_rd = 2'b01;
            for (int i = 0; i < 4; i++) begin
                e_v[i] <= 1'b0; e_rd[i] <= 2'b01; e_err[i] <= 1'b0; e_ctrl[i] <= 1'b0;
            end
        end else begin
            base = load_rd ? ((load_rd_val == 2'b11) ? 2'b00 : load_rd_val) : m_rd;
            err = 1'b0; ctl = 1'b0;
            m_rd = base;
            if (in_valid) begin
                ones = $countones(in_word);
                hi_ones = $countones(in_word[9:4]);
                if (hi_ones == 0 || hi_ones == 6) err = 1'b1;
                if (ones > 5 && base == 2'b10) err = 1'b1;
                if (ones < 5 && base == 2'b01) err = 1'b1;
                if (ones > 5) m_rd = 2'b10;
                else if (ones < 5) m_rd = 2'b01;
                for (int k = 0; k < NC; k++) if (in_word == CTRL_PATS[k]) ctl = 1'b1;
            end
            e_v[0] <= in_valid; e_rd[0] <= m_rd; e_err[0] <= err; e_ctrl[0] <= ctl;
            for (int i = 1; i < 4; i++) begin
                e_v[i] <= e_v[i-1]; e_rd[i] <= e_rd[i-1];
                e_err[i] <= e_err[i-1]; e_ctrl[i] <= e_ctrl[i-1];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == e_v[3], "R2 out_valid", out_valid, e_v[3]);
            chk(out_rd == e_rd[3], "R4,R5,R7 out_rd", out_rd, e_rd[3]);
            chk(out_err == e_err[3], "R3,R6,R7 out_err", out_err, e_err[3]);
            chk(out_ctrl == e_ctrl[3], "R8,R7 out_ctrl", out_ctrl, e_ctrl[3]);
        end
    end

    task automatic put(input bit v, input logic [9:0] w, input bit ld = 0, input logic [1:0] lv = 2'b00);
        @(negedge clk);
        in_valid = v; in_word = w; load_rd = ld; load_rd_val = lv;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset values while held
        chk(!out_valid && !out_err && !out_ctrl && out_rd == 2'b01, "R1 reset state",
            {out_valid, out_err, out_ctrl, out_rd}, 1);
        rst_n = 1'b1;
        put(0, '0);
        put(0, '0);
        // R1: still quiet just after release
        chk(!out_valid && out_rd == 2'b01, "R1 after release", {out_valid, out_rd}, 1);

        // R4: balanced words keep state, heavy then light alternate cleanly
        put(1, 10'b1010101010); put(1, 10'b1100110010);
        put(1, 10'b1110110100); put(1, 10'b0001010010);
        put(1, 10'b1101101100); put(1, 10'b0010010001);
        // R6: two heavy words in a row, then two light words in a row
        put(1, 10'b1110111000); put(1, 10'b1011110100);
        put(1, 10'b0100100100); put(1, 10'b0010010100);
        // R3: upper sub-block all ones / all zeros; lower extremes legal
        put(1, 10'b1111110000); put(1, 10'b0000001111);
        put(1, 10'b1100101111); put(1, 10'b0110100000);
        // R7: bubbles carrying garbage that must be ignored
        put(0, 10'b1111111111); put(0, 10'b0000000000);
        // R8: control patterns under negative and positive state
        put(1, 10'b0011111010); put(1, 10'b1100000101);
        put(1, 10'b0011110100); put(1, 10'b0011111011);
        put(1, 10'b1110101100); put(1, 10'b0011111010);
        // R5: preset on a valid slot, on a bubble, and the 11 code as neutral
        put(1, 10'b1110111000, 1, 2'b10);
        put(0, 10'b0, 1, 2'b10); put(1, 10'b1110111000);
        put(1, 10'b0100100100, 1, 2'b11); put(1, 10'b0100100100);
        put(0, 10'b0, 1, 2'b00); put(1, 10'b1110111000); put(1, 10'b1110111000);
        // mixed pseudo-random stream with occasional bubbles and presets
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            put(lfsr[3:0] != 4'h0, lfsr[15:6], lfsr[5:0] == 6'h15, lfsr[5:4]);
        end
        put(0, '0);
        repeat (6) put(0, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule